// File: doc/BRIEF.md
# Digital Potentiometer Wiper Register Core

This block holds the registers behind a 128-step digital potentiometer. The 7-bit wiper code it drives picks one tap of an external resistor ladder. Code 00h is the tap closest to the low terminal and code 7Fh is the tap closest to the high terminal. Raising the code moves the tap steadily toward the high end. Next to the wiper sit a non-volatile start-up byte and a volatile steering register. A host reaches all three through a plain parallel port made of an address, write data, a write strobe, a read strobe and registered read data.

Address 0 leads to two words. While the steering register (address 2) is 00h, address 0 reaches the start-up byte. Every write there also copies the same value into the wiper. While the steering register is 80h, address 0 reaches only the wiper. The start-up byte is modelled as a store with a fixed programming time, shown on a busy flag.

While the supply is not yet good, the wiper is held at mid-scale (64). When the supply-good input rises, the stored start-up byte is copied into the wiper. The same sequence runs after reset and after every supply dip.

Top module: `wiper_core`

## Requirements
- R1: While reset is asserted and just after it, the wiper reads 64, the steering register reads 00h, the busy flag and error strobe are low, and the start-up byte holds its factory value 40h.
- R2: While supply_ok is low, the wiper is 64 from the next clock edge. On the first edge with supply_ok high in that state, the wiper takes the start-up byte's value.
- R3: With the steering register at 00h, a read of address 0 returns the start-up byte. A write to address 0 sets both the start-up byte and the wiper to the written value.
- R4: With the steering register at 80h, a read of address 0 returns the wiper. A write to address 0 changes only the wiper and does not start a programming cycle.
- R5: Writes to address 2 of any value other than 00h or 80h are ignored. A read of address 2 returns the current steering value.
- R6: A read of address 1 returns 00h. A write to address 1 changes no register.
- R7: A write to the start-up byte sets the busy flag for exactly NV_CYCLES clock cycles. The wiper takes the new value at that same edge.
- R8: While busy is high, any read or write of address 0 is rejected. The block raises err for one cycle and no register changes.
- R9: Bit 7 of a value read from address 0 is always 0. Bit 7 of a value written to address 0 is dropped.
- R10: Any access made while supply_ok is low, or before the recall has completed, is rejected with err and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, also restores the factory start-up byte |
| supply_ok | input | 1 | High when the supply is good enough to read the non-volatile byte |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, updated one edge after an accepted read |
| err | output | 1 | One-cycle pulse after a rejected access |
| nv_busy | output | 1 | Start-up byte programming in progress |
| wiper | output | 7 | Wiper tap code |

## Verification
Two events can land on the same edge: the busy window ending and a new access to address 0. The bench waits until exactly one busy cycle is left and then writes, which must be rejected with err while the wiper stays the same. It then writes again on the very next edge, where the counter has just reached zero, and that write must be accepted and move the wiper. The supply dropping on the same edge as a write is also provoked. That write must be rejected, and the wiper must go to mid-scale.

// File: rtl/wiper_core.sv
module wiper_core #(
  parameter int WIDTH     = 7,
  parameter int NV_CYCLES = 20,
  parameter int MID       = 64,
  parameter int FACTORY   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic [1:0]       addr,
  input  logic [WIDTH:0]   wdata,
  input  logic             wr_en,
  input  logic             rd_en,
  output logic [WIDTH:0]   rdata,
  output logic             err,
  output logic             nv_busy,
  output logic [WIDTH-1:0] wiper
);
  localparam int DW = WIDTH + 1;
  localparam int CW = $clog2(NV_CYCLES + 1);
  localparam logic [DW-1:0] SEL_WIPER = DW'(1) << WIDTH;
  localparam logic [CW-1:0] CNT_LOAD  = CW'(NV_CYCLES);

  logic             run_q;
  logic [WIDTH-1:0] wiper_q, nv_q;
  logic [DW-1:0]    acr_q;
  logic [CW-1:0]    cnt_q;

  wire access  = wr_en | rd_en;
  wire reject  = access & (!run_q | !supply_ok | (addr == 2'd0 && cnt_q != '0));
  wire do_wr   = wr_en & !reject;
  wire do_rd   = rd_en & !reject;
  wire nv_mode = (acr_q == '0);
  wire wr0     = do_wr && addr == 2'd0;
  wire nv_wr   = wr0 & nv_mode;
  wire acr_ok  = (wdata == '0) || (wdata == SEL_WIPER);

  assign wiper   = wiper_q;
  assign nv_busy = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      wiper_q <= WIDTH'(MID);
    end else if (!supply_ok) begin
      run_q   <= 1'b0;
      wiper_q <= WIDTH'(MID);
    end else if (!run_q) begin
      run_q   <= 1'b1;
      wiper_q <= nv_q;
    end else if (wr0) begin
      wiper_q <= wdata[WIDTH-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q  <= WIDTH'(FACTORY);
      cnt_q <= '0;
    end else if (nv_wr) begin
      nv_q  <= wdata[WIDTH-1:0];
      cnt_q <= CNT_LOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acr_q <= '0;
    else if (do_wr && addr == 2'd2 && acr_ok)
      acr_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      err <= reject;
      if (do_rd) begin
        case (addr)
          2'd0:    rdata <= {1'b0, nv_mode ? nv_q : wiper_q};
          2'd2:    rdata <= acr_q;
          default: rdata <= '0;
        endcase
      end
    end
  end
endmodule

module wiper_core_chk #(
  parameter int WIDTH = 7,
  parameter int MID   = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             supply_ok,
  input logic [1:0]       addr,
  input logic             wr_en,
  input logic             rd_en,
  input logic [WIDTH:0]   rdata,
  input logic             err,
  input logic             nv_busy,
  input logic [WIDTH-1:0] wiper,
  input logic             run_q,
  input logic [WIDTH:0]   acr_q
);
  localparam logic [WIDTH:0] SELW = (WIDTH+1)'(1) << WIDTH;

  AST_MID_WHILE_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> wiper == WIDTH'(MID)); // R2
  AST_STEER_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    acr_q == '0 || acr_q == SELW); // R5
  AST_RESERVED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == 2'd1 && run_q && supply_ok |=> rdata == '0); // R6
  AST_NVWRITE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 2'd0 && acr_q == '0 && run_q && supply_ok && !nv_busy |=> nv_busy); // R7
  AST_BUSY_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) && addr == 2'd0 && nv_busy |=> err && $stable(wiper)); // R8
  AST_READ_MSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == 2'd0 && run_q && supply_ok && !nv_busy |=> !rdata[WIDTH]); // R9
  AST_UNPOWERED_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) && !run_q |=> err); // R10
endmodule

bind wiper_core wiper_core_chk #(.WIDTH(WIDTH), .MID(MID)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .addr(addr),
  .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .err(err),
  .nv_busy(nv_busy), .wiper(wiper), .run_q(run_q), .acr_q(acr_q)
);

// File: tb/sim_wiper_core.sv
`timescale 1ns/1ps
module sim_wiper_core;
  localparam int NVC = 20;
  logic clk = 0, rst_n = 0, supply_ok = 1;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] rdata;
  logic err, nv_busy;
  logic [6:0] wiper;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  wiper_core #(.NV_CYCLES(NVC)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .err(err), .nv_busy(nv_busy), .wiper(wiper));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a);
    addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && nv_busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 0; supply_ok = 1;
    repeat (2) @(negedge clk);
    chk(wiper == 7'd64, "R1 wiper in reset", wiper, 64);
    chk(!nv_busy && !err, "R1 busy/err in reset", {nv_busy, err}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(wiper == 7'h40, "R2 recall factory after reset", wiper, 'h40);
    rd(2'd2); chk(rdata == 8'h00, "R1 steering reset", rdata, 0);
    rd(2'd0); chk(rdata == 8'h40, "R1 factory byte", rdata, 'h40);
  endtask

  task automatic t_nv_mode();
    wr(2'd0, 8'h15);
    chk(!err && wiper == 7'h15, "R3 write both: wiper", wiper, 'h15);
    wait_idle();
    rd(2'd0); chk(rdata == 8'h15, "R3 read start-up byte", rdata, 'h15);
  endtask

  task automatic t_wiper_mode();
    wr(2'd2, 8'h80);
    rd(2'd0); chk(rdata == 8'h15, "R4 read wiper", rdata, 'h15);
    wr(2'd0, 8'h70);
    chk(wiper == 7'h70, "R4 wiper only: wiper", wiper, 'h70);
    chk(!nv_busy, "R4 no programming", nv_busy, 0);
    rd(2'd0); chk(rdata == 8'h70, "R4 read wiper back", rdata, 'h70);
    wr(2'd2, 8'h00);
    rd(2'd0); chk(rdata == 8'h15, "R4 start-up byte untouched", rdata, 'h15);
  endtask

  task automatic t_steer_illegal();
    wr(2'd2, 8'h80);
    wr(2'd2, 8'h40); rd(2'd2); chk(rdata == 8'h80, "R5 ignore 40h", rdata, 'h80);
    wr(2'd2, 8'h01); rd(2'd2); chk(rdata == 8'h80, "R5 ignore 01h", rdata, 'h80);
    wr(2'd2, 8'h00); rd(2'd2); chk(rdata == 8'h00, "R5 accept 00h", rdata, 0);
  endtask

  task automatic t_reserved();
    logic [6:0] w0;
    w0 = wiper;
    wr(2'd1, 8'h5A);
    rd(2'd1); chk(rdata == 8'h00, "R6 reserved reads zero", rdata, 0);
    chk(wiper == w0, "R6 wiper unchanged", wiper, w0);
    rd(2'd2); chk(rdata == 8'h00, "R6 steering unchanged", rdata, 0);
    rd(2'd0); chk(rdata == 8'h15, "R6 start-up byte unchanged", rdata, 'h15);
  endtask

  task automatic t_busy_window();
    int n;
    wr(2'd0, 8'h22);
    chk(wiper == 7'h22, "R7 wiper immediate", wiper, 'h22);
    n = 0;
    for (int i = 0; i < 200 && nv_busy; i++) begin n++; @(negedge clk); end
    chk(n == NVC, "R7 busy length", n, NVC);
    wr(2'd0, 8'h33);
    repeat (NVC - 1) @(negedge clk);
    chk(nv_busy, "R8 one busy cycle left", nv_busy, 1);
    wr(2'd0, 8'h44);
    chk(err && wiper == 7'h33, "R8 last busy cycle rejects", wiper, 'h33);
    wr(2'd0, 8'h45);
    chk(!err && wiper == 7'h45, "R8 first free cycle accepts", wiper, 'h45);
    rd(2'd0);
    chk(err == 1, "R8 read while busy rejected", err, 1);
    wait_idle();
    rd(2'd0); chk(rdata == 8'h45, "R8 byte after busy", rdata, 'h45);
  endtask

  task automatic t_msb();
    wr(2'd0, 8'hFF);
    chk(wiper == 7'h7F, "R9 msb dropped on write", wiper, 'h7F);
    wait_idle();
    rd(2'd0); chk(rdata == 8'h7F, "R9 msb zero on read", rdata, 'h7F);
  endtask

  task automatic t_recall();
    supply_ok = 0;
    @(negedge clk);
    chk(wiper == 7'd64, "R2 mid-scale on supply loss", wiper, 64);
    wr(2'd0, 8'h11);
    chk(err && wiper == 7'd64, "R10 access while unpowered", wiper, 64);
    supply_ok = 1;
    @(negedge clk);
    chk(wiper == 7'h7F, "R2 recall after supply good", wiper, 'h7F);
    rd(2'd0); chk(!err && rdata == 8'h7F, "R10 access after recall", rdata, 'h7F);
    supply_ok = 0;
    wr(2'd0, 8'h12);
    chk(err && wiper == 7'd64, "R10 write on supply drop edge", wiper, 64);
    supply_ok = 1;
    @(negedge clk);
    rd(2'd0); chk(rdata == 8'h7F, "R10 byte kept", rdata, 'h7F);
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog expired (all R) actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_nv_mode();
    t_wiper_mode();
    t_steer_illegal();
    t_reserved();
    t_busy_window();
    t_msb();
    t_recall();
    t_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule